// File: doc/BRIEF.md
# Ordered Store-Then-Load Packet Unit

This block executes one two-slot memory packet per accepted cycle against a small local byte memory. Slot 1 may carry a store and slot 0 may carry a load. When both are in the same packet, the store takes effect first. The load therefore sees the freshly written bytes wherever the two byte ranges meet, and sees old memory bytes everywhere else. Accesses are 1, 2, 4 or 8 bytes wide and use little-endian order. Loads of 1, 2 and 4 bytes are sign-extended or zero-extended to 64 bits. The 8-byte load is always taken as unsigned.

Before the early store is allowed to change memory, the unit checks the load for a fault. It checks the store as well. A fault is an access that is not aligned to its own size, or one that touches any byte outside the window `[WIN_BASE, WIN_BASE+MEM_BYTES)`. A faulting packet changes nothing in memory and raises a fault flag.

A load may be predicated. When its predicate is false, the load is skipped and is not checked for a fault, but the store in the same packet still commits. Either slot may also be cancelled. The result reports the cancelled slots as a two-bit mask, and a cancelled store writes nothing. Packets enter through a valid/ready handshake, and each one returns a single registered result one cycle after it is accepted. A packet with no store costs no extra cycle.

Top module: `osl_store_load_unit`

## Requirements
- R1: `pkt_ready` is high from the first clock edge after reset is released. A packet is accepted when `pkt_valid` and `pkt_ready` are both high. Its result appears with `res_valid` high exactly one cycle later. In every cycle with `res_valid` low, `res_data`, `res_fault` and `res_cancel_mask` are zero.
- R2: A load with no live store in its packet returns the memory bytes starting at its address. The byte at the lowest address is the least significant byte of the result.
- R3: When a live store and a load in the same packet cover the same bytes, the load returns the value just stored, and memory holds that value afterwards.
- R4: On a partial overlap, each load byte is taken from the store where the store covers that byte, and from the prior memory otherwise. Extension is applied after this merge.
- R5: The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. With `ld_signed` set, sizes 0 to 2 are sign-extended to 64 bits; otherwise they are zero-extended. Size 3 is never extended.
- R6: A live access is at fault if its address is not a multiple of its size, or if any of its bytes lies outside `[WIN_BASE, WIN_BASE+MEM_BYTES)`. On a fault, `res_fault` is 1 and `res_data` is 0.
- R7: A fault on the load in a packet blocks that packet's store, so memory is unchanged.
- R8: A predicated load with `ld_pred_en=1` and `ld_pred=0` is skipped. It is not fault-checked, it returns 0 and it sets mask bit 0. A store in the same packet still commits.
- R9: `res_cancel_mask` bit 0 reports a cancelled or predicated-off load, and bit 1 reports a cancelled store. A cancelled store leaves memory unchanged. A cancelled load returns 0 and is not fault-checked.
- R10: While reset is applied, `pkt_ready` and `res_valid` are low, and memory is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet offered |
| pkt_ready | output | 1 | Packet can be accepted |
| st_en | input | 1 | Slot 1 holds a store |
| st_cancel | input | 1 | Slot 1 store cancelled |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | 64 | Store data, low bytes used |
| ld_en | input | 1 | Slot 0 holds a load |
| ld_cancel | input | 1 | Slot 0 load cancelled |
| ld_pred_en | input | 1 | Load is predicated |
| ld_pred | input | 1 | Predicate value |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_signed | input | 1 | Sign-extend the load |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Extended load data |
| res_fault | output | 1 | Packet faulted |
| res_cancel_mask | output | 2 | Cancelled slots (bit n = slot n) |

## Verification
The assertions check the following on every cycle:
- Timing relations: one-cycle result latency, quiet outputs when no result is valid, and ready after reset.
- Misaligned live loads always fault.
- Faults always return zero data.
- Unsigned byte loads have clean upper bits.
- Predicated-off loads and cancelled stores report the right mask bits.

Some behaviour depends on what memory holds, so only the bench's reference model can show it:
- store-before-load ordering and per-byte merging on partial overlap;
- a faulting load leaving the store uncommitted;
- a cancelled store leaving memory unchanged;
- window-edge faults.

The bench shows these by reading memory back in later packets.

// File: rtl/osl_pkg.sv
// Shared types for the ordered store/load unit.
// Assumes: a packet lane is one byte and an access spans at most eight lanes.
package osl_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    localparam int LANES = 8;
endpackage

// File: rtl/osl_access_chk.sv
// Fault check for a single access: alignment to its own size and containment
// inside the byte window [WIN_BASE, WIN_BASE+MEM_BYTES). Also returns the
// memory index of the first byte.
// Assumes: WIN_BASE is a multiple of 8, MEM_BYTES is a power of two >= 8.
module osl_access_chk #(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 64,
    parameter int WIN_BASE  = 256,
    parameter int IDX_W     = $clog2(MEM_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              bad,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W:0] nbytes;
    logic [ADDR_W:0] offs;
    logic            misal;
    logic            below;
    logic            above;

    // Byte count, alignment, and window position of the access.
    always_comb begin
        nbytes = (ADDR_W+1)'(1) << size;
        misal  = ({1'b0, addr} & (nbytes - (ADDR_W+1)'(1))) != '0;
        below  = addr < ADDR_W'(WIN_BASE);
        offs   = {1'b0, addr} - (ADDR_W+1)'(WIN_BASE);
        above  = offs > ((ADDR_W+1)'(MEM_BYTES) - nbytes);
        bad    = misal | below | above;
        idx    = offs[IDX_W-1:0];
    end
endmodule

// File: rtl/osl_fwd_merge.sv
// Per-byte forwarding: every load lane takes the store byte when the live
// store covers that address, otherwise the old memory byte.
// Assumes: both accesses are aligned when the result is used (faults zero it).
module osl_fwd_merge #(
    parameter int IDX_W = 6
) (
    input  logic [7:0][7:0]   old_bytes,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [IDX_W-1:0]  st_idx,
    input  logic [1:0]        st_size,
    input  logic              st_live,
    input  logic [63:0]       st_data,
    output logic [63:0]       merged
);
    logic [7:0][7:0] st_bytes;
    logic [7:0][7:0] out_bytes;
    logic [IDX_W:0]  st_nb;

    assign st_bytes = st_data;
    assign st_nb    = (IDX_W+1)'(1) << st_size;
    assign merged   = out_bytes;

    for (genvar g = 0; g < osl_pkg::LANES; g++) begin : g_lane
        logic [IDX_W-1:0] rel;
        logic             hit;
        // Position of this load lane relative to the store start, and the pick.
        always_comb begin
            rel          = (ld_idx + IDX_W'(g)) - st_idx;
            hit          = st_live && ({1'b0, rel} < st_nb);
            out_bytes[g] = hit ? st_bytes[rel[2:0]] : old_bytes[g];
        end
    end
endmodule

// File: rtl/osl_extend.sv
// Sign or zero extension of merged load bytes to 64 bits by size code.
// Assumes: the doubleword size is always treated as unsigned.
module osl_extend (
    input  logic [63:0] raw,
    input  logic [1:0]  size,
    input  logic        sgn,
    output logic [63:0] val
);
    // Select width and fill bits.
    always_comb begin
        case (osl_pkg::acc_size_e'(size))
            osl_pkg::SZ_BYTE: val = {{56{sgn & raw[7]}},  raw[7:0]};
            osl_pkg::SZ_HALF: val = {{48{sgn & raw[15]}}, raw[15:0]};
            osl_pkg::SZ_WORD: val = {{32{sgn & raw[31]}}, raw[31:0]};
            default:          val = raw;
        endcase
    end
endmodule

// File: rtl/osl_store_load_unit.sv
// Two-slot packet unit: the slot 1 store commits before the slot 0 load of the
// same packet, and the load sees the stored bytes through same-cycle
// forwarding. Both live accesses are fault-checked before anything commits.
// A registered result follows one cycle after acceptance.
// Assumes: MEM_BYTES is a power of two >= 16, WIN_BASE is 8-byte aligned.
module osl_store_load_unit #(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 64,
    parameter int WIN_BASE  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic              st_en,
    input  logic              st_cancel,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [63:0]       st_data,
    input  logic              ld_en,
    input  logic              ld_cancel,
    input  logic              ld_pred_en,
    input  logic              ld_pred,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              ld_signed,
    output logic              res_valid,
    output logic [63:0]       res_data,
    output logic              res_fault,
    output logic [1:0]        res_cancel_mask
);
    localparam int IDX_W = $clog2(MEM_BYTES);

    logic [MEM_BYTES-1:0][7:0] mem_q;
    logic                      ready_q;
    logic                      accept;
    logic                      st_live, ld_live, ld_pred_off;
    logic                      st_bad, ld_bad, fault;
    logic                      commit;
    logic [IDX_W-1:0]          st_idx, ld_idx;
    logic [7:0][7:0]           old_bytes;
    logic [7:0][7:0]           st_bytes;
    logic [63:0]               merged, ext;
    int                        st_nb;

    // Slot liveness, packet fault and commit decision.
    always_comb begin
        accept      = pkt_valid & ready_q;
        st_live     = st_en & ~st_cancel;
        ld_pred_off = ld_pred_en & ~ld_pred;
        ld_live     = ld_en & ~ld_cancel & ~ld_pred_off;
        fault       = (ld_live & ld_bad) | (st_live & st_bad);
        commit      = accept & st_live & ~fault;
        st_nb       = 32'sd1 <<< st_size;
    end

    assign st_bytes  = st_data;
    assign pkt_ready = ready_q;

    osl_access_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W))
        u_st_chk (.addr(st_addr), .size(st_size), .bad(st_bad), .idx(st_idx));

    osl_access_chk #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W))
        u_ld_chk (.addr(ld_addr), .size(ld_size), .bad(ld_bad), .idx(ld_idx));

    for (genvar g = 0; g < osl_pkg::LANES; g++) begin : g_old
        assign old_bytes[g] = mem_q[ld_idx + IDX_W'(g)];
    end

    osl_fwd_merge #(.IDX_W(IDX_W)) u_merge (
        .old_bytes (old_bytes),
        .ld_idx    (ld_idx),
        .st_idx    (st_idx),
        .st_size   (st_size),
        .st_live   (st_live),
        .st_data   (st_data),
        .merged    (merged)
    );

    osl_extend u_ext (.raw(merged), .size(ld_size), .sgn(ld_signed), .val(ext));

    // Ready comes up on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Early store commit into the byte memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (commit) begin
            for (int i = 0; i < osl_pkg::LANES; i++) begin
                if (i < st_nb) mem_q[st_idx + IDX_W'(i)] <= st_bytes[i];
            end
        end
    end

    // Registered packet result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid       <= 1'b0;
            res_data        <= '0;
            res_fault       <= 1'b0;
            res_cancel_mask <= '0;
        end else begin
            res_valid       <= accept;
            res_data        <= (accept && ld_live && !fault) ? ext : '0;
            res_fault       <= accept & fault;
            res_cancel_mask <= accept ? {st_en & st_cancel, ld_en & (ld_cancel | ld_pred_off)} : 2'b00;
        end
    end
endmodule

// File: rtl/osl_store_load_unit_chk.sv
// Port-level properties of the ordered store/load unit, bound into the top.
// Assumes: observes the top ports only.
module osl_store_load_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_valid,
    input logic        pkt_ready,
    input logic        st_en,
    input logic        st_cancel,
    input logic        ld_en,
    input logic        ld_cancel,
    input logic        ld_pred_en,
    input logic        ld_pred,
    input logic        ld_addr_lsb,
    input logic [1:0]  ld_size,
    input logic        ld_signed,
    input logic        res_valid,
    input logic [63:0] res_data,
    input logic        res_fault,
    input logic [1:0]  res_cancel_mask
);
    logic acc;
    logic ld_go;
    assign acc   = pkt_valid && pkt_ready;
    assign ld_go = ld_en && !ld_cancel && (!ld_pred_en || ld_pred);

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pkt_ready); // R1
    AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> res_valid); // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !res_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_data == '0 && !res_fault && res_cancel_mask == 2'b00)); // R1
    AST_UNSIGNED_BYTE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ld_en && ld_size == 2'd0 && !ld_signed) |=> res_data[63:8] == '0); // R5
    AST_MISALIGNED_LOAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ld_go && ld_size != 2'd0 && ld_addr_lsb) |=> res_fault); // R6
    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_data == '0); // R6
    AST_PRED_OFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ld_en && !ld_cancel && ld_pred_en && !ld_pred) |=> (res_cancel_mask[0] && res_data == '0)); // R8
    AST_STORE_CANCEL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && st_en && st_cancel) |=> res_cancel_mask[1]); // R9
endmodule

bind osl_store_load_unit osl_store_load_unit_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pkt_valid       (pkt_valid),
    .pkt_ready       (pkt_ready),
    .st_en           (st_en),
    .st_cancel       (st_cancel),
    .ld_en           (ld_en),
    .ld_cancel       (ld_cancel),
    .ld_pred_en      (ld_pred_en),
    .ld_pred         (ld_pred),
    .ld_addr_lsb     (ld_addr[0]),
    .ld_size         (ld_size),
    .ld_signed       (ld_signed),
    .res_valid       (res_valid),
    .res_data        (res_data),
    .res_fault       (res_fault),
    .res_cancel_mask (res_cancel_mask)
);

// File: tb/osl_store_load_unit_test.sv
module osl_store_load_unit_test;
    localparam int ADDR_W    = 16;
    localparam int MEM_BYTES = 64;
    localparam int WIN_BASE  = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_valid = 1'b0;
    logic              pkt_ready;
    logic              st_en = 1'b0, st_cancel = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic [63:0]       st_data = '0;
    logic              ld_en = 1'b0, ld_cancel = 1'b0, ld_pred_en = 1'b0, ld_pred = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [1:0]        ld_size = '0;
    logic              ld_signed = 1'b0;
    logic              res_valid;
    logic [63:0]       res_data;
    logic              res_fault;
    logic [1:0]        res_cancel_mask;

    osl_store_load_unit #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .WIN_BASE(WIN_BASE)) uut (.*);

    always #10 clk = ~clk;

    // Reference state and expectations.
    byte unsigned ref_mem [MEM_BYTES];
    logic        exp_valid = 0, exp_fault = 0, exp_ready = 0;
    logic [63:0] exp_data = '0;
    logic [1:0]  exp_mask = '0;
    string       exp_tag = "R10";
    int          checks = 0, errors = 0, cycles = 0;

    task automatic compare();
        checks++;
        if (res_valid !== exp_valid || res_data !== exp_data || res_fault !== exp_fault ||
            res_cancel_mask !== exp_mask || pkt_ready !== exp_ready) begin
            errors++;
            $display("FAIL %s: got v=%0b d=%h f=%0b m=%b r=%0b, expected v=%0b d=%h f=%0b m=%b r=%0b",
                     exp_tag, res_valid, res_data, res_fault, res_cancel_mask, pkt_ready,
                     exp_valid, exp_data, exp_fault, exp_mask, exp_ready);
        end
    endtask

    function automatic bit ref_bad(int addr, int size);
        int nb = 1 << size;
        return (addr % nb) != 0 || addr < WIN_BASE || addr + nb > WIN_BASE + MEM_BYTES;
    endfunction

    task automatic send(input string tag, input bit se, input bit sc, input int sa, input int ss,
                        input logic [63:0] sd, input bit le, input bit lc, input bit pe, input bit p,
                        input int la, input int ls, input bit lsg);
        bit s_live, l_live, l_off, flt;
        logic [63:0] v;
        @(negedge clk);
        compare();
        st_en = se; st_cancel = sc; st_addr = ADDR_W'(sa); st_size = 2'(ss); st_data = sd;
        ld_en = le; ld_cancel = lc; ld_pred_en = pe; ld_pred = p; ld_addr = ADDR_W'(la);
        ld_size = 2'(ls); ld_signed = lsg; pkt_valid = 1'b1;
        s_live = se && !sc;
        l_off  = pe && !p;
        l_live = le && !lc && !l_off;
        flt = (s_live && ref_bad(sa, ss)) || (l_live && ref_bad(la, ls));
        // Store first, then the load reads the updated memory.
        if (s_live && !flt)
            for (int i = 0; i < (1 << ss); i++) ref_mem[sa - WIN_BASE + i] = sd[8*i +: 8];
        v = '0;
        if (l_live && !flt) begin
            for (int i = 0; i < (1 << ls); i++) v[8*i +: 8] = ref_mem[la - WIN_BASE + i];
            if (lsg && ls < 3 && v[8*(1 << ls) - 1])
                for (int b = 8*(1 << ls); b < 64; b++) v[b] = 1'b1;
        end
        exp_valid = 1; exp_data = v; exp_fault = flt;
        exp_mask = {se && sc, le && (lc || l_off)}; exp_ready = 1; exp_tag = tag;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        compare();
        pkt_valid = 1'b0;
        exp_valid = 0; exp_data = '0; exp_fault = 0; exp_mask = '0; exp_tag = tag;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        foreach (ref_mem[i]) ref_mem[i] = 8'h00;
        // R10: reset state.
        repeat (3) begin @(negedge clk); compare(); end
        @(negedge clk); compare(); rst_n = 1'b1; exp_ready = 1; exp_tag = "R1";
        idle("R1");
        // R2: fresh memory reads zero, then store-only and load-only packets.
        send("R2", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE, 3, 0);
        send("R2", 1,0,WIN_BASE+8,3,64'h8877_6655_4433_2211, 0,0,0,0, 0,0,0);
        send("R2", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+8, 3, 0);
        send("R2", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+10, 1, 0);
        idle("R1");
        // R3: full overlap in one packet.
        send("R3", 1,0,WIN_BASE+16,2,64'h0000_0000_DEAD_BEEF, 1,0,0,0, WIN_BASE+16, 2, 0);
        send("R3", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+16, 2, 0);
        // R4: partial overlap merges per byte.
        send("R4", 1,0,WIN_BASE+9,0,64'hAB, 1,0,0,0, WIN_BASE+8, 2, 0);
        send("R4", 1,0,WIN_BASE+20,2,64'hF0E0_D0C0, 1,0,0,0, WIN_BASE+16, 3, 0);
        send("R4", 1,0,WIN_BASE+14,1,64'h9A80, 1,0,0,0, WIN_BASE+15, 0, 1);
        // R5: extension by size.
        send("R5", 1,0,WIN_BASE+24,3,64'h8000_8000_8080_8080, 1,0,0,0, WIN_BASE+24, 0, 1);
        send("R5", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+24, 0, 0);
        send("R5", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+26, 1, 1);
        send("R5", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+28, 2, 1);
        send("R5", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+24, 3, 1);
        // R6: misaligned and outside-window accesses.
        send("R6", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+2, 2, 0);
        send("R6", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE-8, 3, 0);
        send("R6", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+MEM_BYTES, 0, 0);
        send("R6", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+MEM_BYTES-1, 0, 0);
        send("R6", 1,0,WIN_BASE+33,1,64'h1234, 0,0,0,0, 0,0,0);
        // R7: faulting load blocks its store; read back shows old data.
        send("R7", 1,0,WIN_BASE+32,3,64'hCAFE_F00D_1357_2468, 1,0,0,0, WIN_BASE+33, 1, 0);
        send("R7", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+32, 3, 0);
        // R8: predicated-off load skips the check, store commits.
        send("R8", 1,0,WIN_BASE+40,2,64'h7777_5555, 1,0,1,0, WIN_BASE+1, 2, 0);
        send("R8", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+40, 2, 0);
        send("R8", 1,0,WIN_BASE+44,2,64'h1111_2222, 1,0,1,1, WIN_BASE+40, 3, 0);
        // R9: cancellations.
        send("R9", 1,1,WIN_BASE+48,3,64'hFFFF_FFFF_FFFF_FFFF, 1,0,0,0, WIN_BASE+48, 3, 0);
        send("R9", 1,0,WIN_BASE+48,0,64'h5A, 1,1,0,0, WIN_BASE+3, 3, 0);
        send("R9", 0,0,0,0,64'h0, 1,0,0,0, WIN_BASE+48, 3, 0);
        idle("R1");
        // Mixed traffic across R2, R3, R4, R5, R6, R8 and R9.
        for (int n = 0; n < 400; n++) begin
            int ss = $urandom_range(0, 3);
            int ls = $urandom_range(0, 3);
            int sa = WIN_BASE - 8 + $urandom_range(0, MEM_BYTES + 15);
            int la = WIN_BASE - 8 + $urandom_range(0, MEM_BYTES + 15);
            if ($urandom_range(0, 9) < 8) begin sa = sa & ~((1 << ss) - 1); la = la & ~((1 << ls) - 1); end
            if ($urandom_range(0, 3) == 0) la = sa;
            if ($urandom_range(0, 9) == 0) idle("R1");
            else send("mixed R3", $urandom_range(0,1), $urandom_range(0,7) == 0, sa, ss,
                      {$urandom, $urandom}, $urandom_range(0,4) != 0, $urandom_range(0,7) == 0,
                      $urandom_range(0,3) == 0, $urandom_range(0,1), la, ls, $urandom_range(0,1));
        end
        idle("R1");
        idle("R1");
        finish_run();
    end
endmodule